// File: doc/BRIEF.md
# Keypress Event Buffer with Interrupt

This block holds one keypress event for a host controller and signals it on an active-low interrupt line. A debounced front end reports each new press with a one-cycle strobe. The strobe carries a key code. The front end also drives a level that stays high while the key is held. A free-running tick advances a duration count while the key is down. The host sees the key code and a duration byte. The duration byte packs a saturation flag in bit 7 above a 7-bit tick count in bits 6 to 0.

The block tells two kinds of host read apart:

- **Read while the key is still down.** The read returns the running count and leaves the entry in place. It also lifts the interrupt, so the host can wait for the release without polling.
- **Read after the release.** The read returns the final count, empties the buffer and lifts the interrupt.

A new press always replaces whatever entry is held.

The read port is a plain single-cycle strobe, not a valid/ready stream. A read is always accepted in the cycle it is presented, so there is no back-pressure. The two output bytes are registered state, so they are valid in every cycle. Outputs change one clock after the event that causes them.

Top module: `keypress_evt_buf`

## Requirements
- R1: After reset, `int_n` is 1, `type_byte` is 0x00 and `dur_byte` is 0x00.
- R2: A cycle with `key_valid` high loads `key_code` into `type_byte`, sets `dur_byte` to 0x00 and drives `int_n` to 0 from the next cycle on.
- R3: While the entry is live (pressed, not yet released) and `key_held` is 1, each cycle with `dur_tick` high adds one to `dur_byte[6:0]`.
- R4: When the count reaches 127 it stays at 127, and `dur_byte[7]` becomes 1 in the same cycle; further ticks change nothing.
- R5: A `rd_strobe` while the entry is live leaves `type_byte` and `dur_byte` unchanged and drives `int_n` to 1 from the next cycle on.
- R6: Repeated reads while the key stays held keep `int_n` at 1, and the count keeps advancing on ticks.
- R7: The first cycle with `key_held` at 0 while the entry is live ends the entry. From the next cycle on, `int_n` is 0 and ticks no longer change `dur_byte`.
- R8: A `rd_strobe` when the entry has been released sets `type_byte` and `dur_byte` to 0x00 and `int_n` to 1 from the next cycle on.
- R9: A press while an unread released entry is held overwrites it: the new code is loaded, the count restarts at 0 and `int_n` stays 0.
- R10: A `rd_strobe` when no entry is held changes nothing: `int_n` stays 1 and both bytes stay 0x00.
- R11: When `key_valid` and `rd_strobe` are high in the same cycle, the press takes effect and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe for a debounced new press |
| key_code | input | 8 | Key code, sampled with `key_valid` |
| key_held | input | 1 | High while the key is held down |
| dur_tick | input | 1 | Duration time base, one pulse per count |
| rd_strobe | input | 1 | Host read, one cycle |
| type_byte | output | 8 | Stored key code, 0x00 when empty |
| dur_byte | output | 8 | Bit 7 saturation flag, bits 6:0 tick count |
| int_n | output | 1 | Active-low interrupt |

## Verification
Some rules are checked by assertions on every cycle:

- a press pulls the interrupt low in the next cycle;
- a read of a live entry lifts the interrupt and keeps the entry;
- a read of a released entry empties the buffer;
- the interrupt falls only after a press or a release;
- the saturation flag is never set without a full count;
- the code byte is zero whenever the buffer is empty.

Other behaviour shows only in the bench's scenarios. The exact count for every tick total from 0 to 130 comes from a sweep over press, ticks, release and read. Polling across several reads, overwriting an unread entry, reading an empty buffer, and a press colliding with a read are covered by directed scenarios.

// File: rtl/keybuf_pkg.sv
package keybuf_pkg;
  localparam int KEY_W = 8;
  localparam int CNT_W = 7;
endpackage

// File: rtl/keybuf_dur_counter.sv
module keybuf_dur_counter #(
  parameter int CNT_W = keybuf_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             sat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      sat_q   <= 1'b0;
    end else if (clr) begin
      count_q <= '0;
      sat_q   <= 1'b0;
    end else if (en && count_q != CMAX) begin
      count_q <= count_q + 1'b1;
      if (count_q + 1'b1 == CMAX) sat_q <= 1'b1;
    end
  end

  assign count = count_q;
  assign sat   = sat_q;

  // R4: flag only with a full count
  assert_flag_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> count_q == CMAX);
  // R4: a full count does not move on further ticks
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && count_q == CMAX) |=> (count_q == CMAX && sat_q));
  // R3: a tick below the limit adds one
  assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && count_q != CMAX) |=> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/keybuf_evt_ctrl.sv
module keybuf_evt_ctrl #(
  parameter int KEY_W = keybuf_pkg::KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_code,
  input  logic             key_held,
  input  logic             dur_tick,
  input  logic             rd_strobe,
  output logic [KEY_W-1:0] type_q,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             int_n
);
  logic entry_q, live_q, int_q;
  logic release_ev, keep_rd, clear_rd;

  always_comb begin
    release_ev = live_q && !key_held && !key_valid;
    keep_rd    = rd_strobe && entry_q && live_q && !key_valid;
    clear_rd   = rd_strobe && entry_q && !live_q && !key_valid;
    cnt_clr    = key_valid || clear_rd;
    cnt_en     = live_q && key_held && dur_tick && !key_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= 1'b0;
      live_q  <= 1'b0;
      int_q   <= 1'b1;
      type_q  <= '0;
    end else if (key_valid) begin
      entry_q <= 1'b1;
      live_q  <= 1'b1;
      int_q   <= 1'b0;
      type_q  <= key_code;
    end else begin
      if (release_ev) begin
        live_q <= 1'b0;
        int_q  <= 1'b0;
      end else if (keep_rd) begin
        int_q  <= 1'b1;
      end
      if (clear_rd) begin
        entry_q <= 1'b0;
        int_q   <= 1'b1;
        type_q  <= '0;
      end
    end
  end

  assign int_n = int_q;

  // R2: a press pulls the interrupt low next cycle
  assert_press_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (!int_q && entry_q && type_q == $past(key_code)));
  // R5: a read of a live held entry keeps it and lifts the interrupt
  assert_keep_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && entry_q && live_q && key_held && !key_valid) |=> (int_q && entry_q));
  // R8: a read of a released entry empties the buffer
  assert_clear_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && entry_q && !live_q && !key_valid) |=> (int_q && !entry_q && type_q == '0));
  // R7: the interrupt falls only after a press or a release
  assert_int_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_q) |-> ($past(key_valid) || $past(live_q && !key_held)));
  // R10: an empty buffer shows a zero code
  assert_empty_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_q |-> (type_q == '0 && int_q));
endmodule

// File: rtl/keypress_evt_buf.sv
module keypress_evt_buf #(
  parameter int KEY_W = keybuf_pkg::KEY_W,
  parameter int CNT_W = keybuf_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_code,
  input  logic             key_held,
  input  logic             dur_tick,
  input  logic             rd_strobe,
  output logic [KEY_W-1:0] type_byte,
  output logic [CNT_W:0]   dur_byte,
  output logic             int_n
);
  logic             cnt_clr, cnt_en, sat;
  logic [CNT_W-1:0] count;

  keybuf_evt_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_held(key_held), .dur_tick(dur_tick), .rd_strobe(rd_strobe),
    .type_q(type_byte), .cnt_clr(cnt_clr), .cnt_en(cnt_en), .int_n(int_n)
  );

  keybuf_dur_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .count(count), .sat(sat)
  );

  assign dur_byte = {sat, count};
endmodule

// File: tb/tb_keypress_evt_buf.sv
module tb_keypress_evt_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_valid = 1'b0;
  logic [7:0] key_code = 8'h00;
  logic       key_held = 1'b0;
  logic       dur_tick = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] type_byte, dur_byte;
  logic       int_n;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  keypress_evt_buf dut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_held(key_held), .dur_tick(dur_tick), .rd_strobe(rd_strobe),
    .type_byte(type_byte), .dur_byte(dur_byte), .int_n(int_n)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] t, input logic [7:0] d, input logic i);
    checks = checks + 1;
    if (type_byte !== t || dur_byte !== d || int_n !== i) begin
      fails = fails + 1;
      $display("FAIL %s: actual type=%02h dur=%02h int_n=%b, expected type=%02h dur=%02h int_n=%b",
               req, type_byte, dur_byte, int_n, t, d, i);
    end
  endtask

  task automatic press(input logic [7:0] code);
    key_valid = 1'b1; key_code = code; key_held = 1'b1;
    cyc();
    key_valid = 1'b0;
  endtask

  task automatic rd();
    rd_strobe = 1'b1;
    cyc();
    rd_strobe = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      dur_tick = 1'b1; cyc();
      dur_tick = 1'b0; cyc();
    end
  endtask

  function automatic logic [7:0] dur_exp(input int n);
    int c;
    c = (n > 127) ? 127 : n;
    return {(n >= 127) ? 1'b1 : 1'b0, c[6:0]};
  endfunction

  initial begin
    cyc(); cyc();
    chk("R1 reset", 8'h00, 8'h00, 1'b1);
    rst_n = 1'b1;
    cyc();
    chk("R1 after reset", 8'h00, 8'h00, 1'b1);

    // R10: read of an empty buffer
    rd(); cyc();
    chk("R10 empty read", 8'h00, 8'h00, 1'b1);

    // sweep over tick totals: R2 R3 R4 R7 R8
    for (int n = 0; n <= 130; n++) begin
      logic [7:0] code;
      code = 8'(n * 7 + 1);
      press(code);
      chk("R2 press", code, 8'h00, 1'b0);
      ticks(n);
      chk("R3 R4 held count", code, dur_exp(n), 1'b0);
      key_held = 1'b0; cyc();
      chk("R7 release", code, dur_exp(n), 1'b0);
      ticks(2);
      chk("R7 frozen after release", code, dur_exp(n), 1'b0);
      rd();
      chk("R8 clear read", 8'h00, 8'h00, 1'b1);
    end

    // R5 R6: polling while held
    press(8'hA5);
    ticks(3);
    rd();
    chk("R5 live read keeps entry", 8'hA5, 8'h03, 1'b1);
    ticks(2);
    chk("R6 int stays high, count runs", 8'hA5, 8'h05, 1'b1);
    rd(); rd();
    chk("R6 repeated reads", 8'hA5, 8'h05, 1'b1);
    key_held = 1'b0; cyc();
    chk("R7 release after poll", 8'hA5, 8'h05, 1'b0);

    // R9: overwrite unread released entry
    press(8'h3C);
    chk("R9 overwrite", 8'h3C, 8'h00, 1'b0);
    ticks(1);
    key_held = 1'b0; cyc();
    rd();
    chk("R8 clear after overwrite", 8'h00, 8'h00, 1'b1);

    // R11: press and read in the same cycle
    rd_strobe = 1'b1;
    press(8'h77);
    rd_strobe = 1'b0;
    chk("R11 press wins over read", 8'h77, 8'h00, 1'b0);
    key_held = 1'b0; cyc();
    rd_strobe = 1'b1;
    press(8'h12);
    rd_strobe = 1'b0;
    chk("R11 press wins over clearing read", 8'h12, 8'h00, 1'b0);
    key_held = 1'b0; cyc();
    rd();
    chk("R8 final clear", 8'h00, 8'h00, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule